// File: doc/BRIEF.md
# Serial DAC Input Register Interface

This block is the digital front end that sits behind the three serial pins of a voltage-output DAC. A host drives an active-low frame select, a serial clock and a data line. While the frame is open, the block samples the data line on each falling edge of the serial clock, most significant bit first. When the 24-bit frame is complete, it loads a new conversion code and a two-bit power mode in a single step. All logic runs on a local system clock. The three pins are first passed through synchronizer flops, and the edges of the serial clock and frame select are found in the system clock domain. The serial clock must therefore be several times slower than the system clock.

A frame commits only on its 24th falling serial clock edge. If frame select returns high before that edge, the frame is dropped: the partial contents are discarded and neither register changes. Once a frame has committed, further edges in the same frame are ignored. Frame select must then go high and fall again before the next frame can start. A parameter sets the resolution to 16 or 12 bits. In the 12-bit variant the code is taken left aligned from the data field, and its last four bit times are not stored. The analog path is represented only by the decoded mode outputs: the output amplifier drives the pin, or one of three termination choices replaces it.

Top module: `serial_dac_frontend`

## Requirements
- R1: After reset the code output is all zeros, the mode is 00 (normal, amplifier driving), drive_en is 1 and no update strobe has been issued.
- R2: A frame opens only when frame select goes from high to low. If frame select is already low when reset ends, falling clock edges load nothing until frame select has been high and falls again.
- R3: Bits are sampled on falling serial clock edges, most significant first, into frame bit positions 23 down to 0. Bits 23..18 are ignored, bits 17..16 are the mode field (bit 17 is the upper mode bit) and bits 15..0 are the data field.
- R4: With RES_BITS = 16, the code after a committed frame equals frame bits 15..0.
- R5: With RES_BITS = 12, the code after a committed frame equals frame bits 15..4, and frame bits 3..0 have no effect.
- R6: The code and the mode change together, only on the 24th falling edge of a frame. upd_strobe is high for exactly one system clock cycle per committed frame, in the same cycle the new values first appear.
- R7: If frame select goes high after 1 to 23 falling edges, the partial frame is discarded: the code, the mode and the strobe are unaffected, and the next complete frame loads only its own bits.
- R8: Falling edges after the 24th within the same frame load nothing and cause no further strobe.
- R9: After a commit, a new frame needs frame select to go high and fall again. If frame select stays low, another 24 edges change nothing.
- R10: Mode encoding: 00 normal (drive_en), 01 1 kΩ to ground (term_1k), 10 100 kΩ to ground (term_100k), 11 high impedance (term_open). Exactly one of the four outputs is high at any time.
- R11: The code register keeps its value while a power-down mode is selected. A power-down frame still loads its data field, and the code output is not forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_sel_n | input | 1 | Active-low frame select pin (asynchronous) |
| ser_clk | input | 1 | Serial clock pin; data are sampled on its falling edge |
| ser_din | input | 1 | Serial data pin |
| dac_code | output | RES_BITS | Current conversion code |
| pwr_mode | output | 2 | Current power mode field |
| drive_en | output | 1 | Amplifier drives the output (mode 00) |
| term_1k | output | 1 | Output tied to ground through 1 kΩ (mode 01) |
| term_100k | output | 1 | Output tied to ground through 100 kΩ (mode 10) |
| term_open | output | 1 | Output left high impedance (mode 11) |
| upd_strobe | output | 1 | One-cycle pulse when a frame commits |

## Verification
A miscounted bit counter shows up at the ports at the end of the very next frame. The frame commits one edge early or late, so the code appears shifted by one bit position, or it is missing and the strobe count falls behind. An abort path that fails to clear the window leaks bits from the dropped frame into the code of the next frame. A wrong state after a commit turns trailing edges, or edges sent with frame select still low, into extra strobes and changed codes within a single frame time. The sweep walks a single set bit across every data and mode position under all four modes, and aborts at every edge count from 1 to 23. Each of these faults is therefore visible a few system cycles after the frame in which it happens.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    localparam int FRAME_W  = 24;
    localparam int MODE_W   = 2;
    localparam int DATA_W   = 16;

    typedef enum logic [1:0] {
        PM_NORMAL  = 2'b00,
        PM_PD_1K   = 2'b01,
        PM_PD_100K = 2'b10,
        PM_PD_OPEN = 2'b11
    } pwr_mode_e;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'b00,
        FS_SHIFT = 2'b01,
        FS_DONE  = 2'b10
    } frm_state_e;

endpackage

// File: rtl/sdac_pin_sync.sv
module sdac_pin_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.chain[0] = pin_i;
        for (int s = 1; s < STAGES; s++) begin
            sync_d.chain[s] = sync_q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign lvl_o = sync_q.chain[STAGES-1];

endmodule

// File: rtl/sdac_frame_shifter.sv
module sdac_frame_shifter
    import sdac_pkg::*;
#(
    parameter int RES_BITS = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sel_lvl,
    input  logic                       sck_lvl,
    input  logic                       din_lvl,
    output logic                       commit_o,
    output logic [MODE_W+RES_BITS-1:0] window_o
);

    localparam int CNT_W    = $clog2(FRAME_W);
    localparam int KEEP_W   = MODE_W + RES_BITS;
    localparam int TAIL     = DATA_W - RES_BITS;
    localparam int STORE_N  = FRAME_W - TAIL;
    localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] STORE_LIM = CNT_W'(STORE_N);

    typedef struct packed {
        frm_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [KEEP_W-1:0] win;
        logic              commit;
        logic              sel_prev;
        logic              sck_prev;
    } shf_t;

    shf_t shf_d, shf_q;
    logic sel_fall, sck_fall, keep_bit;

    assign sel_fall = shf_q.sel_prev & ~sel_lvl;
    assign sck_fall = shf_q.sck_prev & ~sck_lvl;

    generate
        if (TAIL > 0) begin : g_tail
            assign keep_bit = (shf_q.cnt < STORE_LIM);
        end else begin : g_full
            assign keep_bit = 1'b1;
        end
    endgenerate

    always_comb begin
        shf_d          = shf_q;
        shf_d.commit   = 1'b0;
        shf_d.sel_prev = sel_lvl;
        shf_d.sck_prev = sck_lvl;
        unique case (shf_q.state)
            FS_IDLE: begin
                if (sel_fall) begin
                    shf_d.state = FS_SHIFT;
                    shf_d.cnt   = '0;
                    shf_d.win   = '0;
                end
            end
            FS_SHIFT: begin
                if (sel_lvl) begin
                    shf_d.state = FS_IDLE;
                    shf_d.cnt   = '0;
                    shf_d.win   = '0;
                end else if (sck_fall) begin
                    if (keep_bit) begin
                        shf_d.win = {shf_q.win[KEEP_W-2:0], din_lvl};
                    end
                    if (shf_q.cnt == LAST_IDX) begin
                        shf_d.state  = FS_DONE;
                        shf_d.commit = 1'b1;
                        shf_d.cnt    = '0;
                    end else begin
                        shf_d.cnt = shf_q.cnt + 1'b1;
                    end
                end
            end
            FS_DONE: begin
                if (sel_lvl) begin
                    shf_d.state = FS_IDLE;
                end
            end
            default: begin
                shf_d.state = FS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shf_q       <= '0;
            shf_q.state <= FS_IDLE;
        end else begin
            shf_q <= shf_d;
        end
    end

    assign commit_o = shf_q.commit;
    assign window_o = shf_q.win;

    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (shf_q.state == FS_SHIFT && sel_lvl) |=> (shf_q.state == FS_IDLE && shf_q.win == '0 && !commit_o)); // R7
    AST_COMMIT_FROM_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> ($past(shf_q.state) == FS_SHIFT && shf_q.state == FS_DONE)); // R6
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (shf_q.state == FS_DONE && $past(shf_q.state) == FS_DONE) |-> !commit_o); // R8
    AST_DONE_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (shf_q.state == FS_DONE && !sel_lvl) |=> (shf_q.state == FS_DONE)); // R9

endmodule

// File: rtl/sdac_code_reg.sv
module sdac_code_reg
    import sdac_pkg::*;
#(
    parameter int RES_BITS = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit_i,
    input  logic [MODE_W+RES_BITS-1:0] window_i,
    output logic [RES_BITS-1:0]        code_o,
    output pwr_mode_e                  mode_o,
    output logic                       upd_o
);

    localparam int KEEP_W = MODE_W + RES_BITS;

    typedef struct packed {
        logic [RES_BITS-1:0] code;
        pwr_mode_e           mode;
        logic                upd;
    } reg_t;

    reg_t reg_d, reg_q;

    always_comb begin
        reg_d     = reg_q;
        reg_d.upd = commit_i;
        if (commit_i) begin
            reg_d.code = window_i[RES_BITS-1:0];
            reg_d.mode = pwr_mode_e'(window_i[KEEP_W-1 -: MODE_W]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q      <= '0;
            reg_q.mode <= PM_NORMAL;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign code_o = reg_q.code;
    assign mode_o = reg_q.mode;
    assign upd_o  = reg_q.upd;

    AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> ($stable(code_o) && $stable(mode_o))); // R7
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o); // R6
    AST_STROBE_FOLLOWS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> upd_o); // R6

endmodule

// File: rtl/sdac_mode_decode.sv
module sdac_mode_decode
    import sdac_pkg::*;
(
    input  pwr_mode_e mode_i,
    output logic      drive_o,
    output logic      t1k_o,
    output logic      t100k_o,
    output logic      topen_o
);

    always_comb begin
        drive_o = 1'b0;
        t1k_o   = 1'b0;
        t100k_o = 1'b0;
        topen_o = 1'b0;
        unique case (mode_i)
            PM_NORMAL:  drive_o = 1'b1;
            PM_PD_1K:   t1k_o   = 1'b1;
            PM_PD_100K: t100k_o = 1'b1;
            PM_PD_OPEN: topen_o = 1'b1;
            default:    drive_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/serial_dac_frontend.sv
module serial_dac_frontend
    import sdac_pkg::*;
#(
    parameter int RES_BITS    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frm_sel_n,
    input  logic                ser_clk,
    input  logic                ser_din,
    output logic [RES_BITS-1:0] dac_code,
    output logic [1:0]          pwr_mode,
    output logic                drive_en,
    output logic                term_1k,
    output logic                term_100k,
    output logic                term_open,
    output logic                upd_strobe
);

    localparam int PIN_W  = 3;
    localparam int KEEP_W = MODE_W + RES_BITS;

    logic [PIN_W-1:0]  pins_lvl;
    logic              commit;
    logic [KEEP_W-1:0] window;
    pwr_mode_e         mode;

    sdac_pin_sync #(
        .W      (PIN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({frm_sel_n, ser_clk, ser_din}),
        .lvl_o (pins_lvl)
    );

    sdac_frame_shifter #(
        .RES_BITS (RES_BITS)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_lvl  (pins_lvl[2]),
        .sck_lvl  (pins_lvl[1]),
        .din_lvl  (pins_lvl[0]),
        .commit_o (commit),
        .window_o (window)
    );

    sdac_code_reg #(
        .RES_BITS (RES_BITS)
    ) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .window_i (window),
        .code_o   (dac_code),
        .mode_o   (mode),
        .upd_o    (upd_strobe)
    );

    sdac_mode_decode u_dec (
        .mode_i  (mode),
        .drive_o (drive_en),
        .t1k_o   (term_1k),
        .t100k_o (term_100k),
        .topen_o (term_open)
    );

    assign pwr_mode = mode;

    AST_ONE_TERMINATION: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({drive_en, term_1k, term_100k, term_open}) == 1); // R10
    AST_PD_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_strobe && pwr_mode != 2'b00) |-> $stable(dac_code)); // R11

endmodule

// File: tb/serial_dac_frontend_tb_top.sv
module serial_dac_frontend_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fsel_n = 1'b0;
    logic sclk = 1'b1;
    logic sdi = 1'b0;

    logic [15:0] code16;
    logic [11:0] code12;
    logic [1:0]  mode16, mode12;
    logic d16, k1_16, k100_16, op16, st16;
    logic d12, k1_12, k100_12, op12, st12;

    int tests = 0;
    int fails = 0;
    int str16 = 0, str12 = 0, dbl = 0;
    logic st16_prev = 1'b0;
    bit  done = 1'b0;

    logic [15:0] exp16 = '0;
    logic [11:0] exp12 = '0;
    logic [1:0]  expm  = '0;
    int          exps  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_dac_frontend #(.RES_BITS(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .frm_sel_n(fsel_n), .ser_clk(sclk), .ser_din(sdi),
        .dac_code(code16), .pwr_mode(mode16), .drive_en(d16), .term_1k(k1_16),
        .term_100k(k100_16), .term_open(op16), .upd_strobe(st16));

    serial_dac_frontend #(.RES_BITS(12)) dut12_i (
        .clk(clk), .rst_n(rst_n), .frm_sel_n(fsel_n), .ser_clk(sclk), .ser_din(sdi),
        .dac_code(code12), .pwr_mode(mode12), .drive_en(d12), .term_1k(k1_12),
        .term_100k(k100_12), .term_open(op12), .upd_strobe(st12));

    always @(negedge clk) begin
        if (rst_n) begin
            if (st16) str16++;
            if (st12) str12++;
            if (st16 && st16_prev) dbl++;
            st16_prev <= st16;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "code16", 32'(code16), 32'(exp16));
        chk(req, "code12", 32'(code12), 32'(exp12));
        chk(req, "mode16", 32'(mode16), 32'(expm));
        chk(req, "mode12", 32'(mode12), 32'(expm));
        chk(req, "terms16", 32'({op16, k100_16, k1_16, d16}), 32'(1) << expm);
        chk(req, "terms12", 32'({op12, k100_12, k1_12, d12}), 32'(1) << expm);
        chk(req, "strobes16", 32'(str16), 32'(exps));
        chk(req, "strobes12", 32'(str12), 32'(exps));
    endtask

    task automatic send_bits(input logic [23:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            sdi  = w[23-i];
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
            tick(HALF);
        end
        sclk = 1'b1;
        tick(HALF);
    endtask

    task automatic model_commit(input logic [23:0] w);
        exp16 = w[15:0];
        exp12 = w[15:4];
        expm  = w[17:16];
        exps++;
    endtask

    task automatic frame(input logic [23:0] w, input int n);
        fsel_n = 1'b0;
        tick(HALF);
        send_bits(w, n);
        fsel_n = 1'b1;
        tick(8);
        if (n >= 24) model_commit(w);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [23:0] w;
        logic [15:0] data;
        tick(3);
        rst_n = 1'b1;
        tick(4);
        // R1: reset state
        check_all("R1");

        // R2: frame select low since reset, edges must load nothing
        send_bits(24'hFFFFFF, 24);
        tick(8);
        check_all("R2");
        fsel_n = 1'b1;
        tick(8);
        check_all("R2");

        // R3 R4 R5 R10 R6: sweep modes and single-bit / fixed data patterns
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 19; k++) begin
                if (k < 16)       data = 16'(1) << k;
                else if (k == 16) data = 16'h0000;
                else if (k == 17) data = 16'hFFFF;
                else              data = 16'hA5C3;
                w = {6'(k * 11 + m * 5), 2'(m), data};
                frame(w, 24);
                check_all((k % 2 == 0) ? "R4_R3_R6" : "R5_R10");
            end
        end

        // R11: power-down frame still loads data, code not forced to zero
        frame({6'h00, 2'b00, 16'hBEEF}, 24);
        check_all("R11");
        frame({6'h15, 2'b10, 16'hBEEF}, 24);
        check_all("R11");
        chk("R11", "code16 nonzero in pd", 32'(code16 != 0), 32'd1);

        // R7: abort after every partial edge count
        for (int n = 1; n < 24; n++) begin
            w = {6'h3F, 2'b01, 16'hFFFF ^ 16'(n)};
            frame(w, n);
            check_all("R7");
        end
        frame({6'h2A, 2'b11, 16'h1234}, 24);
        check_all("R7");

        // R8: trailing edges after the 24th in the same frame
        fsel_n = 1'b0;
        tick(HALF);
        send_bits({6'h00, 2'b01, 16'h0F0F}, 24);
        tick(8);
        model_commit({6'h00, 2'b01, 16'h0F0F});
        check_all("R8");
        send_bits({6'h3F, 2'b10, 16'hF0F0}, 8);
        tick(8);
        check_all("R8");

        // R9: full second burst with frame select still low
        send_bits({6'h3F, 2'b11, 16'h5555}, 24);
        tick(8);
        check_all("R9");
        fsel_n = 1'b1;
        tick(8);
        frame({6'h01, 2'b00, 16'hC001}, 24);
        check_all("R9");

        // R6: strobe never wider than one cycle
        chk("R6", "double strobe", 32'(dbl), 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule